// File: doc/BRIEF.md
# Prioritized Exception Dispatch Unit

This block keeps one pending flag per exception source. When the core asks it to check, it takes at most one pending exception. Taking an exception saves a return address and a masked copy of the machine-state word. It also writes a new machine-state word and points both the current and the next program counter at a fixed vector address. Only the flag of the exception it served is cleared.

Sources raise their flags with set strobes. The core presents its current PC, next PC and machine-state word together with a check strobe. One clock edge later the updated save registers, machine-state word, PC pair, a one-cycle taken pulse and a cause code appear on the outputs.

Six synchronous causes are always eligible. Three asynchronous causes are only eligible while the external-enable bit of the presented machine-state word is set.

Top module: `exc_dispatch`

## Requirements
- R1: After reset every pending flag is clear, `taken_o` is 0, `cause_o` is 0 and all register outputs (`save_pc_o`, `save_msr_o`, `msr_o`, `pc_o`, `npc_o`) are 0. A set strobe on bit i of `set_i` makes pending bit i read 1 on `pend_o` from the next cycle, and the flag stays set until it is served.
- R2: Pending bit positions and cause codes, in descending priority, are:
  - bit 0: instruction fetch fault, code 1
  - bit 1: program trap, code 2
  - bit 2: system call, code 3
  - bit 3: floating point off, code 4
  - bit 4: data access fault, code 5
  - bit 5: misaligned access, code 6
  - bit 6: external, code 7
  - bit 7: performance counter, code 8
  - bit 8: decrementer, code 9

  The lowest-numbered eligible bit is served.
- R3: Bits 6, 7 and 8 are eligible only when bit 15 of `msr_i` is 1 during the check cycle. Bits 0 to 5 are eligible regardless of `msr_i`.
- R4: On a dispatch, `pc_o` and `npc_o` both become the vector of the served cause:
  - fetch fault 0x400
  - program 0x700
  - system call 0xC00
  - floating point off 0x800
  - data access 0x300
  - misaligned 0x600
  - external 0x500
  - performance 0xF00
  - decrementer 0x900
- R5: On a dispatch, `save_pc_o` becomes `npc_i` for fetch fault, system call, external, performance and decrementer. It becomes `pc_i` for program, floating point off, data access and misaligned.
- R6: On a dispatch, `save_msr_o` is `msr_i & 0x87C0FFFF`. A fetch fault additionally sets bit 30, and a program trap additionally ORs in 0x00020000.
- R7: On a dispatch, `msr_o` is `msr_i`, with bit 16 ORed into bit 0, and then with the bits of 0x0004EF36 cleared.
- R8: A check serves at most one exception and clears only its pending bit. If a set strobe hits that same bit in the dispatch cycle, the bit stays set.
- R9: `taken_o` is high for exactly the cycle after a check that dispatched. In that cycle `cause_o` carries the code from R2. Otherwise `taken_o` is 0.
- R10: A check with no eligible pending bit, or a cycle with no check, leaves `save_pc_o`, `save_msr_o`, `msr_o`, `pc_o`, `npc_o` and the pending flags unchanged, apart from new set strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_i | input | 9 | Per-source set strobes, one bit per pending flag |
| check_i | input | 1 | Request to take one eligible exception |
| pc_i | input | 32 | Current program counter |
| npc_i | input | 32 | Next program counter |
| msr_i | input | 32 | Current machine-state word |
| taken_o | output | 1 | One-cycle pulse: an exception was dispatched |
| cause_o | output | 4 | Code of the dispatched exception |
| save_pc_o | output | 32 | Saved return address |
| save_msr_o | output | 32 | Saved masked machine-state word with cause bits |
| msr_o | output | 32 | Machine-state word after dispatch |
| pc_o | output | 32 | Program counter after dispatch |
| npc_o | output | 32 | Next program counter after dispatch |
| pend_o | output | 9 | Pending flags |

## Verification
A set strobe and the clear that a dispatch applies can hit the same pending bit in one cycle. The bench provokes this by pending the top-priority fetch fault and re-raising it on the same edge that serves it. It then judges `pend_o` on the following cycle: that bit must still be set while the dispatch outputs report the service.

Eligibility gating and priority selection also meet in a single check. Every pending pattern is swept with the enable bit both cleared and set, and each check is compared against an arithmetic model of the winner.

// File: rtl/exc_pkg.sv
// Shared constants and helpers for the exception dispatch unit.
// Assumes a 32-bit machine-state word and nine fixed exception sources.
package exc_pkg;
    localparam int NUM_SRC   = 9;
    localparam int IDX_W     = 4;
    localparam int FIRST_ASY = 6;
    localparam logic [31:0] SAVE_MASK  = 32'h87C0_FFFF;
    localparam logic [31:0] CLEAR_MASK = 32'h0004_EF36;
    localparam int EE_BIT  = 15;
    localparam int ILE_BIT = 16;

    typedef enum logic [IDX_W-1:0] {
        SRC_IFETCH = 4'd0,
        SRC_PROG   = 4'd1,
        SRC_SCALL  = 4'd2,
        SRC_FPOFF  = 4'd3,
        SRC_DACC   = 4'd4,
        SRC_ALIGN  = 4'd5,
        SRC_EXT    = 4'd6,
        SRC_PERF   = 4'd7,
        SRC_DEC    = 4'd8
    } src_e;

    // Vector address for a source index.
    function automatic logic [31:0] vector_of(input logic [IDX_W-1:0] idx);
        case (idx)
            SRC_IFETCH: vector_of = 32'h0000_0400;
            SRC_PROG:   vector_of = 32'h0000_0700;
            SRC_SCALL:  vector_of = 32'h0000_0C00;
            SRC_FPOFF:  vector_of = 32'h0000_0800;
            SRC_DACC:   vector_of = 32'h0000_0300;
            SRC_ALIGN:  vector_of = 32'h0000_0600;
            SRC_EXT:    vector_of = 32'h0000_0500;
            SRC_PERF:   vector_of = 32'h0000_0F00;
            default:    vector_of = 32'h0000_0900;
        endcase
    endfunction

    // True when the source resumes after the faulting instruction (saves next PC).
    function automatic logic saves_next(input logic [IDX_W-1:0] idx);
        case (idx)
            SRC_PROG, SRC_FPOFF, SRC_DACC, SRC_ALIGN: saves_next = 1'b0;
            default:                                  saves_next = 1'b1;
        endcase
    endfunction
endpackage

// File: rtl/exc_pending.sv
// Pending flag register: one flag per source.
// A set strobe wins over a clear of the same flag in the same cycle.
module exc_pending #(
    parameter int N = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    // Update flags: clear served bit, then OR in new requests.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/exc_arbiter.sv
// Fixed-priority selector: the lowest eligible index wins.
// Sources at or above FIRST_ASY are masked unless the enable input is high.
module exc_arbiter #(
    parameter int N         = 9,
    parameter int IW        = 4,
    parameter int FIRST_ASY = 6
) (
    input  logic [N-1:0]  pend_i,
    input  logic          ee_i,
    output logic          ok_o,
    output logic [IW-1:0] idx_o
);
    logic [N-1:0] elig;

    // Build eligibility mask per source.
    generate
        for (genvar g = 0; g < N; g++) begin : g_elig
            if (g >= FIRST_ASY) begin : g_asy
                assign elig[g] = pend_i[g] & ee_i;
            end else begin : g_syn
                assign elig[g] = pend_i[g];
            end
        end
    endgenerate

    // Scan from lowest priority upward so the highest priority overwrites.
    always_comb begin
        ok_o  = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                ok_o  = 1'b1;
                idx_o = i[IW-1:0];
            end
        end
    end
endmodule

// File: rtl/exc_update.sv
// Computes the register values written when a given source is dispatched.
// Purely combinational; the caller decides whether to commit them.
module exc_update
    import exc_pkg::*;
#(
    parameter int XW = 32
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [XW-1:0]    pc_i,
    input  logic [XW-1:0]    npc_i,
    input  logic [XW-1:0]    msr_i,
    output logic [XW-1:0]    save_pc_o,
    output logic [XW-1:0]    save_msr_o,
    output logic [XW-1:0]    msr_o,
    output logic [XW-1:0]    vec_o
);
    // Return address chooses the current or next PC by source.
    assign save_pc_o = saves_next(idx_i) ? npc_i : pc_i;

    // Saved state: masked word plus per-source cause bits.
    always_comb begin
        save_msr_o = msr_i & SAVE_MASK;
        if (idx_i == SRC_IFETCH) save_msr_o[30] = 1'b1;
        if (idx_i == SRC_PROG)   save_msr_o[17] = 1'b1;
    end

    // New state: copy the exception-endian bit to bit 0, then clear the mask.
    always_comb begin
        msr_o    = msr_i;
        msr_o[0] = msr_i[0] | msr_i[ILE_BIT];
        msr_o    = msr_o & ~CLEAR_MASK;
    end

    assign vec_o = vector_of(idx_i);
endmodule

// File: rtl/exc_dispatch.sv
// Top of the exception dispatch unit. Holds pending flags and the
// architectural result registers, and serves one exception per check.
// Assumes the core presents pc_i, npc_i and msr_i valid with check_i.
module exc_dispatch
    import exc_pkg::*;
#(
    parameter int XW = 32,
    parameter int N  = NUM_SRC
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  set_i,
    input  logic          check_i,
    input  logic [XW-1:0] pc_i,
    input  logic [XW-1:0] npc_i,
    input  logic [XW-1:0] msr_i,
    output logic          taken_o,
    output logic [3:0]    cause_o,
    output logic [XW-1:0] save_pc_o,
    output logic [XW-1:0] save_msr_o,
    output logic [XW-1:0] msr_o,
    output logic [XW-1:0] pc_o,
    output logic [XW-1:0] npc_o,
    output logic [N-1:0]  pend_o
);
    logic [N-1:0]     pend, clr;
    logic             ok, fire;
    logic [IDX_W-1:0] idx;
    logic [XW-1:0]    n_save_pc, n_save_msr, n_msr, n_vec;

    exc_pending #(.N(N)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .clr_i(clr), .pend_o(pend)
    );

    exc_arbiter #(.N(N), .IW(IDX_W), .FIRST_ASY(FIRST_ASY)) u_arb (
        .pend_i(pend), .ee_i(msr_i[EE_BIT]), .ok_o(ok), .idx_o(idx)
    );

    exc_update #(.XW(XW)) u_upd (
        .idx_i(idx), .pc_i(pc_i), .npc_i(npc_i), .msr_i(msr_i),
        .save_pc_o(n_save_pc), .save_msr_o(n_save_msr),
        .msr_o(n_msr), .vec_o(n_vec)
    );

    assign fire = check_i & ok;
    assign clr  = fire ? (N'(1) << idx) : '0;

    // Commit dispatch results; hold everything otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o    <= 1'b0;
            cause_o    <= '0;
            save_pc_o  <= '0;
            save_msr_o <= '0;
            msr_o      <= '0;
            pc_o       <= '0;
            npc_o      <= '0;
        end else begin
            taken_o <= fire;
            cause_o <= fire ? 4'(idx) + 4'd1 : 4'd0;
            if (fire) begin
                save_pc_o  <= n_save_pc;
                save_msr_o <= n_save_msr;
                msr_o      <= n_msr;
                pc_o       <= n_vec;
                npc_o      <= n_vec;
            end
        end
    end

    assign pend_o = pend;
endmodule

// File: rtl/exc_dispatch_chk.sv
// Property checker for exc_dispatch, attached by bind.
module exc_dispatch_chk #(
    parameter int XW = 32,
    parameter int N  = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          check_i,
    input logic [XW-1:0] msr_i,
    input logic          taken_o,
    input logic [3:0]    cause_o,
    input logic [XW-1:0] save_pc_o,
    input logic [XW-1:0] msr_o,
    input logic [XW-1:0] pc_o,
    input logic [XW-1:0] npc_o,
    input logic [N-1:0]  pend_o
);
    p_taken_after_check_r9: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> $past(check_i));
    p_cause_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (cause_o >= 4'd1 && cause_o <= 4'd9));
    p_pc_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> (pc_o == npc_o));
    p_async_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (taken_o && cause_o >= 4'd7) |-> $past(msr_i[15]));
    p_ee_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        taken_o |-> !msr_o[15]);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_o |-> ($stable(save_pc_o) && $stable(pc_o) && $stable(msr_o)));
    p_one_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(pend_o) & ~pend_o) <= 1);
endmodule

bind exc_dispatch exc_dispatch_chk #(.XW(XW), .N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .check_i(check_i), .msr_i(msr_i),
    .taken_o(taken_o), .cause_o(cause_o), .save_pc_o(save_pc_o),
    .msr_o(msr_o), .pc_o(pc_o), .npc_o(npc_o), .pend_o(pend_o)
);

// File: tb/exc_dispatch_bench.sv
// Sweeps every pending pattern with the enable bit off and on, draining
// each pattern check by check against an arithmetic model.
module exc_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  set_i = '0;
    logic        check_i = 1'b0;
    logic [31:0] pc_i = '0, npc_i = '0, msr_i = '0;
    logic        taken_o;
    logic [3:0]  cause_o;
    logic [31:0] save_pc_o, save_msr_o, msr_o, pc_o, npc_o;
    logic [8:0]  pend_o;

    int total = 0, bad = 0, cycles = 0;
    logic [8:0]  m_pend;
    logic [31:0] m_spc, m_smsr, m_msr, m_pc;

    always #10 clk = ~clk;

    exc_dispatch u_exc_dispatch (
        .clk(clk), .rst_n(rst_n), .set_i(set_i), .check_i(check_i),
        .pc_i(pc_i), .npc_i(npc_i), .msr_i(msr_i),
        .taken_o(taken_o), .cause_o(cause_o), .save_pc_o(save_pc_o),
        .save_msr_o(save_msr_o), .msr_o(msr_o), .pc_o(pc_o),
        .npc_o(npc_o), .pend_o(pend_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++;
            $display("FAIL watchdog act=%0d exp<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic logic [31:0] vec(input int k);
        case (k)
            0: vec = 32'h400; 1: vec = 32'h700; 2: vec = 32'hC00;
            3: vec = 32'h800; 4: vec = 32'h300; 5: vec = 32'h600;
            6: vec = 32'h500; 7: vec = 32'hF00; default: vec = 32'h900;
        endcase
    endfunction

    // One check; extra_set is raised on the same edge. Returns whether taken.
    task automatic do_check(input logic ee, input logic [31:0] seed,
                            input logic [8:0] extra_set, output logic tk);
        int win;
        logic [31:0] pc, npc, msr, t;
        pc  = 32'h1000_0000 + (seed << 3);
        npc = pc + 32'd4;
        msr = 32'hA5A5_5A5A ^ (seed * 32'h0101_0107);
        msr[15] = ee;
        pc_i = pc; npc_i = npc; msr_i = msr;
        check_i = 1'b1; set_i = extra_set;
        @(posedge clk);
        @(negedge clk);
        check_i = 1'b0; set_i = '0;
        win = -1;
        for (int k = 8; k >= 0; k--)
            if (m_pend[k] && (k < 6 || ee)) win = k;
        tk = (win >= 0);
        chk("R9 taken", {31'd0, taken_o}, {31'd0, tk});
        if (tk) begin
            chk("R2 cause", {28'd0, cause_o}, win + 1);
            m_pend[win] = 1'b0;
            m_pc  = vec(win);
            m_spc = (win == 1 || win == 3 || win == 4 || win == 5) ? pc : npc;
            m_smsr = msr & 32'h87C0_FFFF;
            if (win == 0) m_smsr = m_smsr | 32'h4000_0000;
            if (win == 1) m_smsr = m_smsr | 32'h0002_0000;
            t = msr | ((msr >> 16) & 32'd1);
            m_msr = t & ~32'h0004_EF36;
        end else begin
            chk("R10 cause", {28'd0, cause_o}, 32'd0);
        end
        m_pend = m_pend | extra_set;
        chk("R4 pc", pc_o, m_pc);
        chk("R4 npc", npc_o, m_pc);
        chk("R5 save pc", save_pc_o, m_spc);
        chk("R6 save msr", save_msr_o, m_smsr);
        chk("R7 msr", msr_o, m_msr);
        chk("R8 pending", {23'd0, pend_o}, {23'd0, m_pend});
    endtask

    task automatic drain(input logic ee, input logic [31:0] seed);
        logic tk;
        for (int n = 0; n < 11; n++) begin
            do_check(ee, seed + n, 9'd0, tk);
            if (!tk) break;
        end
    endtask

    initial begin
        m_pend = '0; m_spc = '0; m_smsr = '0; m_msr = '0; m_pc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 pend", {23'd0, pend_o}, 32'd0);
        chk("R1 taken", {31'd0, taken_o}, 32'd0);
        chk("R1 msr", msr_o, 32'd0);
        chk("R1 pc", pc_o, 32'd0);
        chk("R1 save", save_pc_o | save_msr_o | npc_o, 32'd0);

        for (int p = 1; p < 512; p++) begin
            for (int e = 0; e < 2; e++) begin
                set_i = p[8:0];
                @(posedge clk);
                @(negedge clk);
                set_i = '0;
                m_pend = p[8:0];
                chk("R1 set", {23'd0, pend_o}, {23'd0, m_pend});
                // R3: with enable off, async bits must survive the drain.
                drain(e[0], 32'(p * 16 + e));
                if (m_pend != 0) drain(1'b1, 32'(p * 16 + 8));
            end
        end

        // R8: set and clear of the same bit in the dispatch cycle.
        begin
            logic tk;
            set_i = 9'h101;
            @(posedge clk);
            @(negedge clk);
            set_i = '0;
            m_pend = 9'h101;
            do_check(1'b1, 32'd77, 9'h001, tk);
            chk("R8 collision", {23'd0, pend_o}, 32'h101);
            drain(1'b1, 32'd90);
        end

        // R10: no check means no change even with pending bits.
        set_i = 9'h010;
        @(posedge clk);
        @(negedge clk);
        set_i = '0;
        m_pend = 9'h010;
        repeat (3) @(negedge clk);
        chk("R10 idle pc", pc_o, m_pc);
        chk("R10 idle pend", {23'd0, pend_o}, 32'h010);
        drain(1'b0, 32'd123);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule